// File: doc/BRIEF.md
# Rotated Tiled-View Address Generator

This unit maps a pixel coordinate in a tiled two-dimensional container onto a 32-bit address in tiled address space. The caller supplies the pixel column and row, one of four pixel formats (8-bit, 16-bit and 32-bit tiled, and page mode) and one of eight view codes. Each view code is some mix of a 0, 90, 180 or 270 degree turn and mirroring. Mirroring is done by inverting the coordinate bits against the field mask of the format. A quarter turn is done by swapping the order of the column and row fields in the offset. The view code and the format code are placed in the five top address bits, so that the address decoder further down can pick the right view.

With every address the unit also gives the row stride in bytes for the chosen view, and a flag that marks whether the coordinate fits inside the container for that format. A coordinate outside the container gives an all-zero address with the flag cleared. The result is registered once. It appears one clock after a request and holds until the next request.

Top module: `tiled_view_agen`

## Requirements
- R1: On a valid result, address bits [28:27] hold the format code: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit, 3 for page mode.
- R2: On a valid result, address bits [31:29] hold the 3-bit view code unchanged.
- R3: If the column exceeds the column mask, or the row exceeds the row mask, then the address is 0 and `addr_ok` is low.
- R4: The per-format (column shift, row shift) pairs are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,6) for page mode. The column field is 14 minus the column shift bits wide. The row field is 13 minus the row shift bits wide. The largest in-range coordinate is all ones in its field.
- R5: View code bit 0 XORs the column with its mask. View code bit 1 XORs the row with its mask.
- R6: View code bit 2 set gives the offset (column << row_bits) + row. Clear, it gives (row << column_bits) + column.
- R7: The offset is shifted left by the sum of the two shifts before the mode bits are inserted. The low 1, 2 or 12 address bits are therefore zero for the 16-bit, 32-bit and page formats.
- R8: The stride is 1 << (13 + column shift) when view code bit 2 is set, and 1 << (14 + row shift) otherwise.
- R9: A request with `in_valid` high gives its result and `out_valid` high exactly one clock later. After reset `out_valid`, `addr`, `addr_ok` and `stride` are 0.
- R10: While `in_valid` is low the inputs are ignored: `addr`, `addr_ok` and `stride` keep their last values and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Pixel format code |
| in_view | input | 3 | View code (bit0 column invert, bit1 row invert, bit2 swap) |
| in_x | input | 16 | Pixel column |
| in_y | input | 16 | Pixel row |
| out_valid | output | 1 | Result strobe, one clock after request |
| addr | output | 32 | Tiled-space address |
| addr_ok | output | 1 | Coordinate was inside the container |
| stride | output | 32 | Row stride in bytes for the chosen view |

## Verification
The checker watches every cycle. It confirms that results arrive one clock after a request and hold while no request is made. It confirms that a rejected coordinate always comes with a zero address, and that the mode bits echo the request. It also checks that the stride is a single power of two and that the 16-bit, 32-bit and page addresses keep their low bits clear. Whether the inversion, the field swap and the range limits give the right offset for each format can only be shown by the bench. The bench compares every result against a model: first at the field edges and for every view code, then across a long seeded random run.

// File: rtl/tiled_view_pkg.sv
package tiled_view_pkg;

    typedef enum logic [1:0] {
        FMT_8B   = 2'd0,
        FMT_16B  = 2'd1,
        FMT_32B  = 2'd2,
        FMT_PAGE = 2'd3
    } fmt_e;

    localparam int VIEW_XINV = 0;
    localparam int VIEW_YINV = 1;
    localparam int VIEW_SWAP = 2;
    localparam int SHIFT_W   = 5;

endpackage

// File: rtl/tview_geom.sv
module tview_geom #(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int SW_BITS = 6,
    parameter int SH_BITS = 6
) (
    input  tiled_view_pkg::fmt_e                     fmt,
    output logic [tiled_view_pkg::SHIFT_W-1:0]       x_shift,
    output logic [tiled_view_pkg::SHIFT_W-1:0]       y_shift,
    output logic [tiled_view_pkg::SHIFT_W-1:0]       x_bits,
    output logic [tiled_view_pkg::SHIFT_W-1:0]       y_bits,
    output logic [CW_BITS-1:0]                       x_mask,
    output logic [CH_BITS-1:0]                       y_mask
);
    import tiled_view_pkg::*;

    localparam logic [SHIFT_W-1:0] CW_L = SHIFT_W'(CW_BITS);
    localparam logic [SHIFT_W-1:0] CH_L = SHIFT_W'(CH_BITS);

    always_comb begin
        case (fmt)
            FMT_8B:   begin x_shift = '0;                 y_shift = '0;                 end
            FMT_16B:  begin x_shift = '0;                 y_shift = SHIFT_W'(1);        end
            FMT_32B:  begin x_shift = SHIFT_W'(1);        y_shift = SHIFT_W'(1);        end
            default:  begin x_shift = SHIFT_W'(SW_BITS);  y_shift = SHIFT_W'(SH_BITS);  end
        endcase
        x_bits = CW_L - x_shift;
        y_bits = CH_L - y_shift;
        x_mask = {CW_BITS{1'b1}} >> x_shift;
        y_mask = {CH_BITS{1'b1}} >> y_shift;
    end

endmodule

// File: rtl/tview_mirror.sv
module tview_mirror #(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int COORD_W = 16
) (
    input  logic [COORD_W-1:0] x_in,
    input  logic [COORD_W-1:0] y_in,
    input  logic [CW_BITS-1:0] x_mask,
    input  logic [CH_BITS-1:0] y_mask,
    input  logic               x_inv,
    input  logic               y_inv,
    output logic               in_range,
    output logic [CW_BITS-1:0] x_out,
    output logic [CH_BITS-1:0] y_out
);
    always_comb begin
        in_range = (x_in <= COORD_W'(x_mask)) && (y_in <= COORD_W'(y_mask));
        x_out    = x_in[CW_BITS-1:0] ^ (x_inv ? x_mask : '0);
        y_out    = y_in[CH_BITS-1:0] ^ (y_inv ? y_mask : '0);
    end

endmodule

// File: rtl/tview_pack.sv
module tview_pack #(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    localparam int OFF_W  = CW_BITS + CH_BITS,
    localparam int ADDR_W = OFF_W + 5
) (
    input  logic [CW_BITS-1:0]                 x_f,
    input  logic [CH_BITS-1:0]                 y_f,
    input  logic [tiled_view_pkg::SHIFT_W-1:0] x_bits,
    input  logic [tiled_view_pkg::SHIFT_W-1:0] y_bits,
    input  logic [tiled_view_pkg::SHIFT_W-1:0] x_shift,
    input  logic [tiled_view_pkg::SHIFT_W-1:0] y_shift,
    input  logic [2:0]                         view,
    input  logic [1:0]                         fmt_code,
    input  logic                               in_range,
    output logic [ADDR_W-1:0]                  addr,
    output logic [ADDR_W-1:0]                  stride
);
    import tiled_view_pkg::*;

    logic [OFF_W-1:0] xw, yw, lin, off;

    always_comb begin
        xw = OFF_W'(x_f);
        yw = OFF_W'(y_f);
        if (view[VIEW_SWAP]) begin
            lin    = (xw << y_bits) + yw;
            stride = ADDR_W'(1) << (SHIFT_W'(CH_BITS) + x_shift);
        end else begin
            lin    = (yw << x_bits) + xw;
            stride = ADDR_W'(1) << (SHIFT_W'(CW_BITS) + y_shift);
        end
        off  = lin << (x_shift + y_shift);
        addr = in_range ? {view, fmt_code, off} : '0;
    end

endmodule

// File: rtl/tiled_view_agen.sv
module tiled_view_agen #(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int SW_BITS = 6,
    parameter int SH_BITS = 6,
    parameter int COORD_W = 16,
    localparam int ADDR_W = CW_BITS + CH_BITS + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_fmt,
    input  logic [2:0]        in_view,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    output logic              out_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_ok,
    output logic [ADDR_W-1:0] stride
);
    import tiled_view_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              ok;
        logic [ADDR_W-1:0] stride;
    } res_t;

    res_t res_d, res_q;

    logic [SHIFT_W-1:0] xs, ys, xb, yb;
    logic [CW_BITS-1:0] xm, xf;
    logic [CH_BITS-1:0] ym, yf;
    logic               rng_ok;
    logic [ADDR_W-1:0]  addr_c, stride_c;

    tview_geom #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
        .SW_BITS(SW_BITS), .SH_BITS(SH_BITS)
    ) u_geom (
        .fmt    (fmt_e'(in_fmt)),
        .x_shift(xs),
        .y_shift(ys),
        .x_bits (xb),
        .y_bits (yb),
        .x_mask (xm),
        .y_mask (ym)
    );

    tview_mirror #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .COORD_W(COORD_W)
    ) u_mirror (
        .x_in    (in_x),
        .y_in    (in_y),
        .x_mask  (xm),
        .y_mask  (ym),
        .x_inv   (in_view[VIEW_XINV]),
        .y_inv   (in_view[VIEW_YINV]),
        .in_range(rng_ok),
        .x_out   (xf),
        .y_out   (yf)
    );

    tview_pack #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS)
    ) u_pack (
        .x_f     (xf),
        .y_f     (yf),
        .x_bits  (xb),
        .y_bits  (yb),
        .x_shift (xs),
        .y_shift (ys),
        .view    (in_view),
        .fmt_code(in_fmt),
        .in_range(rng_ok),
        .addr    (addr_c),
        .stride  (stride_c)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.addr   = addr_c;
            res_d.ok     = rng_ok;
            res_d.stride = stride_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign addr      = res_q.addr;
    assign addr_ok   = res_q.ok;
    assign stride    = res_q.stride;

endmodule

// File: rtl/tiled_view_agen_chk.sv
module tiled_view_agen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_fmt,
    input logic [2:0]        in_view,
    input logic              out_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_ok,
    input logic [ADDR_W-1:0] stride
);
    assert_req_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(addr) && $stable(stride) && $stable(addr_ok)));

    assert_reject_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !addr_ok) |-> (addr == '0));

    assert_mode_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!addr_ok || addr[ADDR_W-1:ADDR_W-5] == {$past(in_view), $past(in_fmt)}));

    assert_stride_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(stride) == 1));

    assert_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && addr_ok) |->
            ((addr[ADDR_W-4:ADDR_W-5] == 2'd1) ? (addr[0] == 1'b0) :
             (addr[ADDR_W-4:ADDR_W-5] == 2'd2) ? (addr[1:0] == 2'b00) :
             (addr[ADDR_W-4:ADDR_W-5] == 2'd3) ? (addr[11:0] == 12'h000) : 1'b1));

endmodule

bind tiled_view_agen tiled_view_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_fmt   (in_fmt),
    .in_view  (in_view),
    .out_valid(out_valid),
    .addr     (addr),
    .addr_ok  (addr_ok),
    .stride   (stride)
);

// File: tb/tiled_view_agen_tb.sv
module tiled_view_agen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_view = '0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic        out_valid;
    logic [31:0] addr;
    logic        addr_ok;
    logic [31:0] stride;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tiled_view_agen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_view(in_view), .in_x(in_x), .in_y(in_y), .out_valid(out_valid),
        .addr(addr), .addr_ok(addr_ok), .stride(stride)
    );

    function automatic int xsh(input int f);
        case (f) 0: return 0; 1: return 0; 2: return 1; default: return 6; endcase
    endfunction
    function automatic int ysh(input int f);
        case (f) 0: return 0; 1: return 1; 2: return 1; default: return 6; endcase
    endfunction
    function automatic longint xmask(input int f);
        return (64'd1 << (14 - xsh(f))) - 1;
    endfunction
    function automatic longint ymask(input int f);
        return (64'd1 << (13 - ysh(f))) - 1;
    endfunction
    function automatic bit exp_ok(input int f, input longint x, input longint y);
        return (x <= xmask(f)) && (y <= ymask(f));
    endfunction
    function automatic longint exp_addr(input int f, input int v, input longint x, input longint y);
        longint xx, yy, off;
        if (!exp_ok(f, x, y)) return 0;
        xx = v[0] ? (x ^ xmask(f)) : x;
        yy = v[1] ? (y ^ ymask(f)) : y;
        if (v[2]) off = (xx << (13 - ysh(f))) + yy;
        else      off = (yy << (14 - xsh(f))) + xx;
        off = off << (xsh(f) + ysh(f));
        return (longint'(v) << 29) | (longint'(f) << 27) | off;
    endfunction
    function automatic longint exp_stride(input int f, input int v);
        return v[2] ? (64'd1 << (13 + xsh(f))) : (64'd1 << (14 + ysh(f)));
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input int f, input int v, input int x, input int y);
        @(negedge clk);
        in_valid = 1'b1; in_fmt = 2'(f); in_view = 3'(v);
        in_x = 16'(x); in_y = 16'(y);
        @(negedge clk);
        check({tag, " addr"},   longint'(addr),    exp_addr(f, v, x, y));
        check({tag, " ok"},     longint'(addr_ok), longint'(exp_ok(f, x, y)));
        check({tag, " stride"}, longint'(stride),  exp_stride(f, v));
        check({tag, " valid"},  longint'(out_valid), 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", longint'(out_valid), 0);
        check("R9 reset addr", longint'(addr), 0);
        check("R9 reset stride", longint'(stride), 0);
        rst_n = 1'b1;

        run("R1 R6 basic 8b", 0, 0, 5, 3);
        for (int f = 0; f < 4; f++) begin
            run("R4 max corner", f, 0, int'(xmask(f)), int'(ymask(f)));
            run("R3 x over", f, 0, int'(xmask(f)) + 1, 0);
            run("R3 y over", f, 0, 0, int'(ymask(f)) + 1);
            run("R7 low bits", f, 0, 1, 1);
            run("R8 stride swapped", f, 4, 2, 7);
        end
        run("R3 far out", 3, 2, 16'hFFFF, 16'hFFFF);
        for (int v = 0; v < 8; v++) begin
            run("R5 invert", 1, v, 1, 2);
            run("R6 swap", 2, v, 100, 37);
            run("R2 view code", 0, v, 0, 0);
        end

        // R10: inputs change while idle; outputs must hold
        run("R10 setup", 2, 5, 9, 11);
        @(negedge clk);
        in_valid = 1'b0; in_fmt = 2'd3; in_view = 3'd1; in_x = 16'd4; in_y = 16'd4;
        @(negedge clk);
        @(negedge clk);
        check("R10 hold addr", longint'(addr), exp_addr(2, 5, 9, 11));
        check("R10 hold stride", longint'(stride), exp_stride(2, 5));
        check("R10 hold ok", longint'(addr_ok), 1);
        check("R10 out_valid low", longint'(out_valid), 0);

        for (int i = 0; i < 500; i++) begin
            int f, v, x, y;
            f = int'($urandom % 4);
            v = int'($urandom % 8);
            x = int'($urandom % (xmask(f) + 3));
            y = int'($urandom % (ymask(f) + 3));
            run("R2 R6 random", f, v, x, y);
        end

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 strobe drops", longint'(out_valid), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule